// File: doc/BRIEF.md
# Stereo Sample Gain, Routing and Mute Stage

This block sits in a stereo audio path, between the sample input interface and the noise-shaping modulators. Each accepted left/right sample pair first passes through a routing matrix that picks, for each output channel, silence, the left input, the right input, or the average of the two. Each routed channel is then scaled by an 8-bit gain code. The result is finally multiplied by a soft-mute ramp gain, and the sample is presented one clock later with a valid strobe.

Gain codes take effect in two steps. A new code can sit on the configuration inputs while its commit bit is low without touching the audio. The code is captured into the active gain only on a cycle in which the commit bit is high. A shared-gain select lets the left active code drive both channels. Muting is never abrupt. A mute request moves a 0..256 ramp gain down by one count per accepted sample, and releasing the request moves it back up at the same rate.

The mute request is the OR of three sources: a configuration mute bit, an external mute input, and an automute latch qualified by an enable. The latch sets after a long run of sample pairs that are zero on both channels. It clears on the first pair that is not all zero. The latch is also brought out as a status flag.

Top module: `chan_gain_router`

## Requirements
- R1: During and after reset, `out_valid`, `out_left`, `out_right` and `auto_muted` are 0. Both active gain codes are 0xFF and the ramp gain is at full scale (256), so with routing 1001 the first samples pass unchanged.
- R2: A routed sample x on an output channel with active code c is scaled to floor(x*g/256), where g = c for c below 0xFF and g = 256 for c = 0xFF. Code 0x00 therefore gives 0, and code 0xFF is exact unity.
- R3: A code on `att_left`/`att_right` while `ld_left`/`ld_right` is 0 has no effect on the output. The code present on a clock edge where the load bit is 1 becomes the active code for samples accepted in later cycles. The sample accepted on that same edge still uses the old code.
- R4: When `att_shared` is 1, the right output channel uses the left active code. When it is 0, the right output channel uses its own active code.
- R5: `route[1:0]` selects the source of the left output and `route[3:2]` selects the source of the right output. The encoding is 00 = zero, 01 = left input, 10 = right input, 11 = floor((L+R)/2) computed on 25 bits, so it never overflows. 1001 is stereo, 0110 swaps the channels and 1111 is mono.
- R6: The mute request is `cfg_mute` OR `ext_mute` OR (automute latch AND `zdet_en`). The latch alone, with `zdet_en` at 0, does not attenuate the output.
- R7: When `in_valid` is high at a clock edge, `out_valid` is high for the following cycle and carries that sample's result. Otherwise `out_valid` is 0 and `out_left`/`out_right` hold their last values.
- R8: The automute latch (`auto_muted`) sets on the edge that accepts the 1024th consecutive pair with both channels zero. It clears on the edge that accepts any pair that is not all zero.
- R9: Each output is multiplied by the ramp gain r as floor(y*r/256). The value of r used is the one held before the edge that accepts the sample. On each accepted sample, r then falls by 1 (to no lower than 0) while the mute request is high, and rises by 1 (to no higher than 256) while it is low.
- R10: Cycles with `in_valid` low change neither the ramp gain nor the zero-run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample pair strobe |
| in_left | input | 24 | Signed left input sample |
| in_right | input | 24 | Signed right input sample |
| att_left | input | 8 | Pending left gain code |
| ld_left | input | 1 | Commit pending left gain code |
| att_right | input | 8 | Pending right gain code |
| ld_right | input | 1 | Commit pending right gain code |
| att_shared | input | 1 | Use left active code for both channels |
| route | input | 4 | Output routing code |
| cfg_mute | input | 1 | Configuration soft-mute request |
| zdet_en | input | 1 | Let the automute latch request mute |
| ext_mute | input | 1 | External soft-mute request |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 24 | Processed left output sample |
| out_right | output | 24 | Processed right output sample |
| auto_muted | output | 1 | Automute latch status |

## Verification
The hardest situation to reach is the automute path with the enable set. Reaching it needs an unbroken run of 1024 all-zero pairs. The ramp must then be observed on nonzero data while the latch has already cleared on that data's first sample, so the attenuation seen comes only from the ramp still climbing back. The stimulus reaches this with a directed run of exactly 1023 zero pairs (latch still clear), one more pair (latch set), and then nonzero samples first with the enable off and then with it on. The random phase supplies biased runs of zero pairs, random idle cycles and random reconfiguration, so that commit, shared-gain and routing changes land on the same edges as accepted samples.

// File: rtl/cgr_pkg.sv
// Shared definitions for the stereo gain/routing/mute stage.
// Assumes: two audio channels, index 0 = left output, 1 = right output.
package cgr_pkg;
    // Source selection for one output channel (two bits of the routing code).
    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_LEFT  = 2'b01,
        SRC_RIGHT = 2'b10,
        SRC_MIX   = 2'b11
    } src_sel_e;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/cgr_code_hold.sv
// Holds one active gain code. A pending code is captured only on a commit
// cycle; at all other times the active code is unaffected by the input.
// Assumes: reset value of full-scale code (all ones).
module cgr_code_hold #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] wr_code,
    input  logic          commit,
    output logic [CW-1:0] eff_code
);
    // Capture pending code on commit, otherwise keep.
    always_ff @(posedge clk) begin
        if (!rst_n)      eff_code <= '1;
        else if (commit) eff_code <= wr_code;
    end

    // Without a commit the active code must not move.
    assert_hold_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(eff_code));
endmodule

// File: rtl/cgr_route.sv
// Routing and mixing matrix: each output channel takes zero, the left input,
// the right input or the floored average, chosen by two bits of the code.
// Assumes: code bits [2*ch+1:2*ch] belong to output channel ch.
module cgr_route
    import cgr_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic [DW-1:0]             in_l,
    input  logic [DW-1:0]             in_r,
    input  logic [2*NUM_CH-1:0]       route_code,
    output logic [NUM_CH-1:0][DW-1:0] routed
);
    logic [DW:0] mix_sum;
    logic [DW-1:0] mix_half;

    // Average with one guard bit; dropping the LSB is an arithmetic shift.
    always_comb begin
        mix_sum  = {in_l[DW-1], in_l} + {in_r[DW-1], in_r};
        mix_half = mix_sum[DW:1];
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        src_sel_e sel;
        assign sel = src_sel_e'(route_code[2*ch +: 2]);
        // Pick this channel's source.
        always_comb begin
            unique case (sel)
                SRC_NONE:  routed[ch] = '0;
                SRC_LEFT:  routed[ch] = in_l;
                SRC_RIGHT: routed[ch] = in_r;
                default:   routed[ch] = mix_half;
            endcase
        end
    end
endmodule

// File: rtl/cgr_scale.sv
// Signed sample times an unsigned fixed-point gain, floored.
// Assumes: gain <= 2**FRAC so the result fits in DW bits.
module cgr_scale #(
    parameter int DW   = 24,
    parameter int GW   = 9,
    parameter int FRAC = 8
) (
    input  logic [DW-1:0] x,
    input  logic [GW-1:0] gain,
    output logic [DW-1:0] y
);
    logic signed [DW+GW:0] prod;
    logic signed [DW+GW:0] shifted;

    // Multiply and drop the fraction bits with an arithmetic shift.
    always_comb begin
        prod    = $signed(x) * $signed({1'b0, gain});
        shifted = prod >>> FRAC;
        y       = shifted[DW-1:0];
    end
endmodule

// File: rtl/cgr_zero_run.sv
// Counts consecutive accepted pairs that are zero on both channels and sets
// a latch when the run reaches ZRUN; any nonzero accepted pair clears both.
// Assumes: the count saturates at ZRUN.
module cgr_zero_run #(
    parameter int ZRUN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic is_zero,
    output logic latched
);
    localparam int ZW = $clog2(ZRUN + 1);
    localparam logic [ZW-1:0] ZLIM = ZW'(ZRUN);

    logic [ZW-1:0] run_cnt;

    // Advance or clear the run count and the latch on accepted pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            latched <= 1'b0;
        end else if (valid) begin
            if (!is_zero) begin
                run_cnt <= '0;
                latched <= 1'b0;
            end else if (run_cnt != ZLIM) begin
                run_cnt <= run_cnt + 1'b1;
                if (run_cnt == ZLIM - 1'b1) latched <= 1'b1;
            end
        end
    end

    assert_latch_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched) |-> $past(valid && is_zero));
    assert_latch_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latched) |-> $past(valid && !is_zero));
    assert_idle_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(run_cnt));
endmodule

// File: rtl/cgr_ramp.sv
// Soft-mute ramp gain: one count per accepted sample towards 0 while a mute
// request is present, towards full scale otherwise.
// Assumes: full scale is 2**FRAC and resets there (unmuted).
module cgr_ramp #(
    parameter int FRAC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          mute_req,
    output logic [FRAC:0] gain
);
    localparam logic [FRAC:0] FULL = (FRAC+1)'(1 << FRAC);

    // Step the ramp once per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain <= FULL;
        end else if (valid) begin
            if (mute_req && gain != '0)      gain <= gain - 1'b1;
            else if (!mute_req && gain != FULL) gain <= gain + 1'b1;
        end
    end

    assert_ramp_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gain <= FULL);
    assert_ramp_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mute_req && gain != '0) |=> (gain == $past(gain) - 1'b1));
    assert_ramp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(gain));
endmodule

// File: rtl/chan_gain_router.sv
// Stereo gain, routing and soft-mute stage. Route/mix, then per-output gain
// code scaling, then soft-mute ramp scaling; one register to the output.
// Assumes: in_valid at most once per cycle; configuration is level-sampled.
module chan_gain_router
    import cgr_pkg::*;
#(
    parameter int DW   = 24,
    parameter int CW   = 8,
    parameter int ZRUN = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_left,
    input  logic [DW-1:0] in_right,
    input  logic [CW-1:0] att_left,
    input  logic          ld_left,
    input  logic [CW-1:0] att_right,
    input  logic          ld_right,
    input  logic          att_shared,
    input  logic [3:0]    route,
    input  logic          cfg_mute,
    input  logic          zdet_en,
    input  logic          ext_mute,
    output logic          out_valid,
    output logic [DW-1:0] out_left,
    output logic [DW-1:0] out_right,
    output logic          auto_muted
);
    localparam int GW = CW + 1;
    localparam logic [GW-1:0] FULL = GW'(1 << CW);

    logic [CW-1:0] eff_l, eff_r;
    logic [NUM_CH-1:0][CW-1:0] ch_code;
    logic [NUM_CH-1:0][DW-1:0] routed, attn, fin;
    logic [GW-1:0] ramp_gain;
    logic mute_req, pair_zero, latch_q;

    cgr_code_hold #(.CW(CW)) u_hold_l (
        .clk(clk), .rst_n(rst_n), .wr_code(att_left), .commit(ld_left), .eff_code(eff_l));
    cgr_code_hold #(.CW(CW)) u_hold_r (
        .clk(clk), .rst_n(rst_n), .wr_code(att_right), .commit(ld_right), .eff_code(eff_r));

    // Code per output channel, with optional sharing of the left code.
    always_comb begin
        ch_code[0] = eff_l;
        ch_code[1] = att_shared ? eff_l : eff_r;
    end

    cgr_route #(.DW(DW)) u_route (
        .in_l(in_left), .in_r(in_right), .route_code(route), .routed(routed));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_scale
        logic [GW-1:0] code_gain;
        // All-ones code means exact unity.
        assign code_gain = (ch_code[ch] == '1) ? FULL : {1'b0, ch_code[ch]};
        cgr_scale #(.DW(DW), .GW(GW), .FRAC(CW)) u_att (
            .x(routed[ch]), .gain(code_gain), .y(attn[ch]));
        cgr_scale #(.DW(DW), .GW(GW), .FRAC(CW)) u_mute (
            .x(attn[ch]), .gain(ramp_gain), .y(fin[ch]));
    end

    // Zero-pair detect and combined mute request.
    always_comb begin
        pair_zero = (in_left == '0) && (in_right == '0);
        mute_req  = cfg_mute | ext_mute | (latch_q & zdet_en);
    end

    cgr_zero_run #(.ZRUN(ZRUN)) u_zrun (
        .clk(clk), .rst_n(rst_n), .valid(in_valid), .is_zero(pair_zero), .latched(latch_q));
    cgr_ramp #(.FRAC(CW)) u_ramp (
        .clk(clk), .rst_n(rst_n), .valid(in_valid), .mute_req(mute_req), .gain(ramp_gain));

    assign auto_muted = latch_q;

    // Output register: capture the processed pair on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_left  <= fin[0];
                out_right <= fin[1];
            end
        end
    end

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_left) && $stable(out_right)));
endmodule

// File: tb/chan_gain_router_test.sv
`timescale 1ns/1ps
module chan_gain_router_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, in_valid, ld_left, ld_right, att_shared, cfg_mute, zdet_en, ext_mute;
    logic [23:0] in_left, in_right;
    logic [7:0] att_left, att_right;
    logic [3:0] route;
    logic out_valid, auto_muted;
    logic [23:0] out_left, out_right;

    chan_gain_router uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .att_left(att_left), .ld_left(ld_left), .att_right(att_right), .ld_right(ld_right),
        .att_shared(att_shared), .route(route), .cfg_mute(cfg_mute), .zdet_en(zdet_en),
        .ext_mute(ext_mute), .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .auto_muted(auto_muted));

    int n_chk = 0, n_fail = 0;
    // Reference model state
    int m_effl = 255, m_effr = 255, m_gain = 256, m_zcnt = 0;
    bit m_latch = 1'b0;
    longint prev_l = 0, prev_r = 0;

    function automatic longint sx(logic [23:0] v);
        return longint'($signed(v));
    endfunction
    function automatic longint pick(int sel, longint l, longint r);
        case (sel)
            0: return 0;
            1: return l;
            2: return r;
            default: return (l + r) >>> 1;
        endcase
    endfunction
    function automatic longint by_code(longint x, int code);
        longint g = (code == 255) ? 256 : code;
        return (x * g) >>> 8;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive after negedge, check 1ns after posedge.
    task automatic step(string tag, bit v, logic [23:0] l, logic [23:0] r);
        longint el, er, xl, xr;
        bit req;
        in_valid = v; in_left = l; in_right = r;
        xl = sx(l); xr = sx(r);
        el = by_code(pick(int'(route[1:0]), xl, xr), m_effl);
        er = by_code(pick(int'(route[3:2]), xl, xr), att_shared ? m_effl : m_effr);
        el = (el * m_gain) >>> 8;
        er = (er * m_gain) >>> 8;
        req = cfg_mute | ext_mute | (m_latch & zdet_en);
        @(posedge clk);
        if (ld_left)  m_effl = int'(att_left);
        if (ld_right) m_effr = int'(att_right);
        if (v) begin
            if (l == 0 && r == 0) begin
                if (m_zcnt < 1024) m_zcnt++;
                if (m_zcnt == 1024) m_latch = 1'b1;
            end else begin
                m_zcnt = 0; m_latch = 1'b0;
            end
            if (req && m_gain > 0) m_gain--;
            else if (!req && m_gain < 256) m_gain++;
        end
        #1;
        check({tag, " valid"}, longint'(out_valid), longint'(v));
        if (v) begin
            check({tag, " left"}, sx(out_left), el);
            check({tag, " right"}, sx(out_right), er);
            prev_l = el; prev_r = er;
        end else begin
            check({tag, " R7 hold left"}, sx(out_left), prev_l);
            check({tag, " R7 hold right"}, sx(out_right), prev_r);
        end
        check({tag, " R8 latch"}, longint'(auto_muted), longint'(m_latch));
        @(negedge clk);
    endtask

    function automatic logic [23:0] rnd_sample();
        int k = $urandom_range(0, 9);
        if (k == 0) return 24'h7FFFFF;
        if (k == 1) return 24'h800000;
        return 24'($urandom);
    endfunction

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL R7 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; in_valid = 0; in_left = 0; in_right = 0;
        att_left = 8'h10; att_right = 8'h10; ld_left = 0; ld_right = 0;
        att_shared = 0; route = 4'b1001; cfg_mute = 0; zdet_en = 0; ext_mute = 0;
        repeat (4) @(posedge clk);
        #1;
        check("R1 out_valid", longint'(out_valid), 0);
        check("R1 out_left", longint'(out_left), 0);
        check("R1 out_right", longint'(out_right), 0);
        check("R1 auto_muted", longint'(auto_muted), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R3: pending codes without load leave unity gain
        step("R1", 1, 24'd1000, 24'hFFF000);
        step("R3", 1, 24'h400000, 24'h812345);
        // R3: commit on a sample edge; that sample still uses old code
        att_left = 8'h20; ld_left = 1;
        step("R3", 1, 24'd1000, 24'd1000);
        ld_left = 0; att_left = 8'h40;
        step("R3", 1, 24'd1000, 24'd1000);
        check("R3 committed code", sx(out_left), 125);
        // R2: code 0x00 and 0x01
        att_right = 8'h00; ld_right = 1; step("R2", 0, 0, 0); ld_right = 0;
        step("R2", 1, 24'h7FFFFF, 24'h7FFFFF);
        check("R2 zero code", sx(out_right), 0);
        att_right = 8'h01; ld_right = 1; step("R2", 1, 24'h800000, 24'h800000); ld_right = 0;
        step("R2", 1, 24'h800000, 24'h800000);
        // R4: shared code
        att_shared = 1;
        step("R4", 1, 24'd5000, 24'hFFEC78);
        att_shared = 0;
        step("R4", 1, 24'd5000, 24'hFFEC78);
        // R5: all routing codes with both-extreme and mixed inputs
        att_left = 8'hFF; ld_left = 1; att_right = 8'hFF; ld_right = 1;
        step("R5", 0, 0, 0); ld_left = 0; ld_right = 0;
        for (int rc = 0; rc < 16; rc++) begin
            route = 4'(rc);
            step("R5", 1, 24'h7FFFFF, 24'h7FFFFF);
            step("R5", 1, 24'h800000, 24'h7FFFFF);
            step("R5", 1, 24'hFFFFFD, 24'd2);
        end
        route = 4'b1111;
        step("R5", 1, 24'h7FFFFF, 24'h7FFFFF);
        check("R5 mono no overflow", sx(out_left), 24'h7FFFFF);
        route = 4'b1001;
        // R9: mute ramp to zero and back
        cfg_mute = 1;
        for (int i = 0; i < 260; i++) step("R9", 1, 24'h123456, 24'hEDCBAA);
        check("R9 fully muted", sx(out_left), 0);
        cfg_mute = 0;
        for (int i = 0; i < 30; i++) step("R9", 1, 24'h123456, 24'hEDCBAA);
        // R10: idle cycles change nothing
        for (int i = 0; i < 5; i++) step("R10", 0, 24'h555555, 24'h0);
        ext_mute = 1;
        for (int i = 0; i < 10; i++) step("R6", 1, 24'h200000, 24'h200000);
        ext_mute = 0;
        for (int i = 0; i < 260; i++) step("R9", 1, 24'h200000, 24'h200000);
        // R8: run of zeros, latch at exactly 1024
        for (int i = 0; i < 1023; i++) begin
            step("R8", 1, 0, 0);
            if (i % 7 == 0) step("R10", 0, 0, 0);
        end
        check("R8 not yet latched", longint'(auto_muted), 0);
        step("R8", 1, 0, 0);
        check("R8 latched", longint'(auto_muted), 1);
        // R6: latch without enable does not attenuate
        for (int i = 0; i < 3; i++) step("R6", 1, 0, 0);
        step("R6", 1, 24'h300000, 24'h300000);
        check("R6 no mute without enable", sx(out_left), 24'h300000);
        // R6: with enable the latch ramps down
        zdet_en = 1;
        for (int i = 0; i < 1100; i++) step("R6", 1, 0, 0);
        for (int i = 0; i < 20; i++) step("R6", 1, 24'h300000, 24'h300000);
        zdet_en = 0;
        for (int i = 0; i < 300; i++) step("R9", 1, 24'h10, 24'h10);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) == 0) begin
                att_left = 8'($urandom); att_right = 8'($urandom);
                ld_left = 1'($urandom); ld_right = 1'($urandom);
                att_shared = 1'($urandom); route = 4'($urandom);
                cfg_mute = ($urandom_range(0, 5) == 0);
                ext_mute = ($urandom_range(0, 7) == 0);
                zdet_en = 1'($urandom);
            end else begin
                ld_left = 0; ld_right = 0;
            end
            if ($urandom_range(0, 3) == 0)
                step("R2/R5/R9", $urandom_range(0, 4) != 0, 0, 0);
            else
                step("R2/R5/R9", $urandom_range(0, 4) != 0, rnd_sample(), rnd_sample());
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule